// File: doc/BRIEF.md
# Event-to-Task Shortcut and Interrupt Unit

This unit sits beside the byte sequencer of a two-wire bus master. It turns the sequencer's single-cycle event pulses into sticky flags that software can read and clear. It also lets hardware chain one operation into the next without waiting for software. Six enable bits each link a "last byte" event to a start, suspend or stop task. With these links a transmit can roll into a repeated-start read, or a transfer can stop itself. Software task strobes and shortcut-generated tasks are merged and registered, so each task appears as a single clean pulse one cycle after its cause.

An interrupt line is raised while any latched flag has its enable bit set. The interrupt enable state is one register with three views: a plain write, a write-one-to-set view and a write-one-to-clear view. All three views read back the same value.

Register map (3-bit address, 8-bit data):
- 0: shortcut enables, bits [5:0].
- 1: interrupt enable, plain view.
- 2: interrupt enable, set view.
- 3: interrupt enable, clear view.
- 4: event flags.

Event bit positions: 0 stopped, 1 error, 2 suspended, 3 rx-started, 4 tx-started, 5 last-rx, 6 last-tx.

Task bit positions: 0 start-rx, 1 start-tx, 2 stop, 3 suspend, 4 resume.

Top module: `evt_short_irq`

## Requirements
- R1: After reset the shortcut enables, interrupt enables and event flags all read 0, and `task_o` and `irq_o` are 0.
- R2: A 1 on `evt_i[k]` in one cycle makes bit k of the flag register (address 4) read 1 from the next cycle onward. Bit positions are: 0 stopped, 1 error, 2 suspended, 3 rx-started, 4 tx-started, 5 last-rx, 6 last-tx.
- R3: A write to address 4 clears every flag whose data bit is 0 and leaves flags whose data bit is 1 unchanged. An event arriving in the same cycle as its clear keeps its flag set.
- R4: Address 0 holds six shortcut enable bits. Bit 0 links last-tx to start-rx, bit 1 last-tx to suspend, bit 2 last-tx to stop, bit 3 last-rx to start-tx, bit 4 last-rx to suspend, and bit 5 last-rx to stop. Bits [7:6] read 0.
- R5: A software strobe on `sw_task_i[t]` produces a one-cycle pulse on `task_o[t]` in the following cycle. Bit positions are: 0 start-rx, 1 start-tx, 2 stop, 3 suspend, 4 resume.
- R6: When a shortcut is enabled, its source event pulse raises its destination task on `task_o` in the following cycle. A disabled shortcut raises nothing.
- R7: A software strobe and a shortcut aimed at the same task in the same cycle give one single-cycle pulse on that task.
- R8: A write to address 1 loads the 7-bit interrupt enable with the written data.
- R9: A write to address 2 sets each enable bit written as 1 and leaves the others unchanged.
- R10: A write to address 3 clears each enable bit written as 1 and leaves the others unchanged. Addresses 1, 2 and 3 all read the current enable value.
- R11: `irq_o` is 1 exactly while some event flag and its interrupt enable are both 1.
- R12: Addresses 5 to 7 read 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| evt_i | input | 7 | Event pulses from the sequencer |
| sw_task_i | input | 5 | Software task strobes |
| task_o | output | 5 | Registered task pulses to the sequencer |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for `reg_addr_i` |
| irq_o | output | 1 | Interrupt request |

## Verification
The shortcut path is driven from a table that crosses every single shortcut enable with its own source event, the wrong source event, all enables together, and software strobes alone or colliding with a shortcut on the same task. This table tells a wrong source-to-destination mapping apart from a missing one or a duplicated pulse. Directed cases then exercise partial flag clears and the race between an event and its clear. They also cover the three enable views against one another, and an interrupt from a flag whose enable is off compared with one whose enable is on.

// File: rtl/esi_pkg.sv
package esi_pkg;
    localparam int N_EVT   = 7;
    localparam int N_TASK  = 5;
    localparam int N_SHORT = 6;
    localparam int AW      = 3;
    localparam int DW      = 8;

    // event bit positions
    localparam int EV_STOPPED = 0;
    localparam int EV_ERROR   = 1;
    localparam int EV_SUSP    = 2;
    localparam int EV_RXSTART = 3;
    localparam int EV_TXSTART = 4;
    localparam int EV_LASTRX  = 5;
    localparam int EV_LASTTX  = 6;

    // task bit positions
    localparam int TK_STARTRX = 0;
    localparam int TK_STARTTX = 1;
    localparam int TK_STOP    = 2;
    localparam int TK_SUSPEND = 3;
    localparam int TK_RESUME  = 4;

    // shortcut k: source event and destination task
    localparam int SC_SRC [N_SHORT] = '{EV_LASTTX, EV_LASTTX, EV_LASTTX,
                                        EV_LASTRX, EV_LASTRX, EV_LASTRX};
    localparam int SC_DST [N_SHORT] = '{TK_STARTRX, TK_SUSPEND, TK_STOP,
                                        TK_STARTTX, TK_SUSPEND, TK_STOP};

    typedef enum logic [AW-1:0] {
        A_SHORTS  = 3'd0,
        A_IEN     = 3'd1,
        A_IEN_SET = 3'd2,
        A_IEN_CLR = 3'd3,
        A_FLAGS   = 3'd4
    } reg_addr_e;
endpackage

// File: rtl/esi_flags.sv
module esi_flags
    import esi_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [N_EVT-1:0] evt_i,
    input  logic             clr_wr_i,
    input  logic [N_EVT-1:0] keep_mask_i,
    output logic [N_EVT-1:0] flags_o
);
    typedef struct packed {
        logic [N_EVT-1:0] flags;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_wr_i) begin
            st_d.flags = st_q.flags & keep_mask_i;
        end
        // a new event wins over a clear in the same cycle
        st_d.flags = st_d.flags | evt_i;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign flags_o = st_q.flags;
endmodule

// File: rtl/esi_shorts.sv
module esi_shorts
    import esi_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               en_wr_i,
    input  logic [N_SHORT-1:0] en_wdata_i,
    input  logic [N_EVT-1:0]   evt_i,
    input  logic [N_TASK-1:0]  sw_task_i,
    output logic [N_SHORT-1:0] shorts_o,
    output logic [N_TASK-1:0]  task_o
);
    typedef struct packed {
        logic [N_SHORT-1:0] en;
        logic [N_TASK-1:0]  tasks;
    } st_t;

    st_t st_d, st_q;
    logic [N_TASK-1:0] hw_task [N_SHORT+1];

    // chain of ORs: each shortcut adds its destination task when armed
    assign hw_task[0] = '0;
    for (genvar k = 0; k < N_SHORT; k++) begin : g_short
        logic [N_TASK-1:0] one_hot;
        assign one_hot = (N_TASK'(1) << SC_DST[k]);
        assign hw_task[k+1] = hw_task[k] |
            ((st_q.en[k] && evt_i[SC_SRC[k]]) ? one_hot : '0);
    end

    always_comb begin
        st_d       = st_q;
        st_d.tasks = sw_task_i | hw_task[N_SHORT];
        if (en_wr_i) begin
            st_d.en = en_wdata_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign shorts_o = st_q.en;
    assign task_o   = st_q.tasks;
endmodule

// File: rtl/esi_irq.sv
module esi_irq
    import esi_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_plain_i,
    input  logic             wr_set_i,
    input  logic             wr_clr_i,
    input  logic [N_EVT-1:0] wdata_i,
    input  logic [N_EVT-1:0] flags_i,
    output logic [N_EVT-1:0] ien_o,
    output logic             irq_o
);
    typedef struct packed {
        logic [N_EVT-1:0] ien;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (1'b1)
            wr_plain_i: st_d.ien = wdata_i;
            wr_set_i:   st_d.ien = st_q.ien | wdata_i;
            wr_clr_i:   st_d.ien = st_q.ien & ~wdata_i;
            default:    st_d.ien = st_q.ien;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign ien_o = st_q.ien;
    assign irq_o = |(flags_i & st_q.ien);
endmodule

// File: rtl/evt_short_irq.sv
module evt_short_irq
    import esi_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [N_EVT-1:0]  evt_i,
    input  logic [N_TASK-1:0] sw_task_i,
    output logic [N_TASK-1:0] task_o,
    input  logic              reg_wr_i,
    input  logic [AW-1:0]     reg_addr_i,
    input  logic [DW-1:0]     reg_wdata_i,
    output logic [DW-1:0]     reg_rdata_o,
    output logic              irq_o
);
    logic [N_SHORT-1:0] shorts_q;
    logic [N_EVT-1:0]   ien_q;
    logic [N_EVT-1:0]   flags_q;

    logic wr_shorts, wr_plain, wr_set, wr_clr, wr_flags;

    assign wr_shorts = reg_wr_i && (reg_addr_i == A_SHORTS);
    assign wr_plain  = reg_wr_i && (reg_addr_i == A_IEN);
    assign wr_set    = reg_wr_i && (reg_addr_i == A_IEN_SET);
    assign wr_clr    = reg_wr_i && (reg_addr_i == A_IEN_CLR);
    assign wr_flags  = reg_wr_i && (reg_addr_i == A_FLAGS);

    esi_flags u_flags (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .evt_i       (evt_i),
        .clr_wr_i    (wr_flags),
        .keep_mask_i (reg_wdata_i[N_EVT-1:0]),
        .flags_o     (flags_q)
    );

    esi_shorts u_shorts (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .en_wr_i    (wr_shorts),
        .en_wdata_i (reg_wdata_i[N_SHORT-1:0]),
        .evt_i      (evt_i),
        .sw_task_i  (sw_task_i),
        .shorts_o   (shorts_q),
        .task_o     (task_o)
    );

    esi_irq u_irq (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .wr_plain_i (wr_plain),
        .wr_set_i   (wr_set),
        .wr_clr_i   (wr_clr),
        .wdata_i    (reg_wdata_i[N_EVT-1:0]),
        .flags_i    (flags_q),
        .ien_o      (ien_q),
        .irq_o      (irq_o)
    );

    always_comb begin
        unique case (reg_addr_i)
            A_SHORTS:                   reg_rdata_o = DW'(shorts_q);
            A_IEN, A_IEN_SET, A_IEN_CLR: reg_rdata_o = DW'(ien_q);
            A_FLAGS:                    reg_rdata_o = DW'(flags_q);
            default:                    reg_rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/evt_short_irq_chk.sv
module evt_short_irq_chk
    import esi_pkg::*;
(
    input logic               clk_i,
    input logic               rst_ni,
    input logic [N_EVT-1:0]   evt_i,
    input logic [N_TASK-1:0]  sw_task_i,
    input logic [N_TASK-1:0]  task_o,
    input logic               reg_wr_i,
    input logic [AW-1:0]      reg_addr_i,
    input logic [DW-1:0]      reg_wdata_i,
    input logic               irq_o,
    input logic [N_SHORT-1:0] shorts_q,
    input logic [N_EVT-1:0]   ien_q,
    input logic [N_EVT-1:0]   flags_q
);
    // R2 and R3: an event is latched even if a clear lands in the same cycle
    a_r2_event_latched: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (evt_i != '0) |=> ((flags_q & $past(evt_i)) == $past(evt_i)));

    // R5: no task pulse without a software strobe or a last-byte event
    a_r5_task_has_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (task_o != '0) |-> $past((sw_task_i != '0) || evt_i[EV_LASTRX] || evt_i[EV_LASTTX]));

    // R6: last-tx with its stop shortcut armed gives a stop task
    a_r6_lasttx_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (evt_i[EV_LASTTX] && shorts_q[2]) |=> task_o[TK_STOP]);

    // R6: last-rx with its start-tx shortcut armed gives a start-tx task
    a_r6_lastrx_starttx: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (evt_i[EV_LASTRX] && shorts_q[3]) |=> task_o[TK_STARTTX]);

    // R9: bits written through the set view end up enabled
    a_r9_set_view: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_wr_i && reg_addr_i == A_IEN_SET) |=>
        ((ien_q & $past(reg_wdata_i[N_EVT-1:0])) == $past(reg_wdata_i[N_EVT-1:0])));

    // R10: bits written through the clear view end up disabled
    a_r10_clr_view: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_wr_i && reg_addr_i == A_IEN_CLR) |=>
        ((ien_q & $past(reg_wdata_i[N_EVT-1:0])) == '0));

    // R11: no interrupt while no flag is set
    a_r11_no_flag_no_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flags_q == '0) |-> !irq_o);
endmodule

bind evt_short_irq evt_short_irq_chk chk_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .evt_i       (evt_i),
    .sw_task_i   (sw_task_i),
    .task_o      (task_o),
    .reg_wr_i    (reg_wr_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .irq_o       (irq_o),
    .shorts_q    (shorts_q),
    .ien_q       (ien_q),
    .flags_q     (flags_q)
);

// File: tb/evt_short_irq_tb_top.sv
`timescale 1ns/1ps
module evt_short_irq_tb_top;
    logic       clk_i = 1'b0;
    logic       rst_ni = 1'b0;
    logic [6:0] evt_i = '0;
    logic [4:0] sw_task_i = '0;
    logic [4:0] task_o;
    logic       reg_wr_i = 1'b0;
    logic [2:0] reg_addr_i = '0;
    logic [7:0] reg_wdata_i = '0;
    logic [7:0] reg_rdata_o;
    logic       irq_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk_i = ~clk_i;

    evt_short_irq dut_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .evt_i       (evt_i),
        .sw_task_i   (sw_task_i),
        .task_o      (task_o),
        .reg_wr_i    (reg_wr_i),
        .reg_addr_i  (reg_addr_i),
        .reg_wdata_i (reg_wdata_i),
        .reg_rdata_o (reg_rdata_o),
        .irq_o       (irq_o)
    );

    // {shorts[5:0], last_rx, last_tx, sw_task[4:0], expected task[4:0]}
    localparam logic [17:0] VEC [12] = '{
        {6'b000000, 1'b0, 1'b1, 5'b00000, 5'b00000},
        {6'b000001, 1'b0, 1'b1, 5'b00000, 5'b00001},
        {6'b000010, 1'b0, 1'b1, 5'b00000, 5'b01000},
        {6'b000100, 1'b0, 1'b1, 5'b00000, 5'b00100},
        {6'b001000, 1'b1, 1'b0, 5'b00000, 5'b00010},
        {6'b010000, 1'b1, 1'b0, 5'b00000, 5'b01000},
        {6'b100000, 1'b1, 1'b0, 5'b00000, 5'b00100},
        {6'b111111, 1'b1, 1'b1, 5'b00000, 5'b01111},
        {6'b000111, 1'b1, 1'b0, 5'b00000, 5'b00000},
        {6'b000100, 1'b0, 1'b1, 5'b00100, 5'b00100},
        {6'b000000, 1'b0, 1'b0, 5'b10000, 5'b10000},
        {6'b111000, 1'b0, 1'b1, 5'b00000, 5'b00000}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk_i);
        reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
        @(negedge clk_i);
        reg_wr_i = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [2:0] a, input logic [7:0] exp);
        reg_addr_i = a;
        #0.5;
        check(req, 32'(reg_rdata_o), 32'(exp));
    endtask

    task automatic pulse_evt(input logic [6:0] e);
        @(negedge clk_i);
        evt_i = e;
        @(negedge clk_i);
        evt_i = '0;
    endtask

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual 0x0 expected 0x1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;
        @(negedge clk_i);

        // R1: reset state
        check("R1 task", 32'(task_o), 0);
        check("R1 irq", 32'(irq_o), 0);
        rd_check("R1 shorts", 3'd0, 8'h00);
        rd_check("R1 ien", 3'd1, 8'h00);
        rd_check("R1 flags", 3'd4, 8'h00);

        // R4 R5 R6 R7: table of shortcut and strobe patterns
        foreach (VEC[i]) begin
            logic [17:0] v;
            v = VEC[i];
            wr(3'd0, {2'b00, v[17:12]});
            evt_i = {v[10], v[11], 5'b00000};
            sw_task_i = v[9:5];
            @(negedge clk_i);
            evt_i = '0;
            sw_task_i = '0;
            check($sformatf("R6 vec%0d task", i), 32'(task_o), 32'(v[4:0]));
            @(negedge clk_i);
            check($sformatf("R7 vec%0d pulse ends", i), 32'(task_o), 0);
        end

        // R4: shortcut register holds six bits
        wr(3'd0, 8'hFF);
        rd_check("R4 shorts readback", 3'd0, 8'h3F);
        wr(3'd0, 8'h00);

        // R2 R3: flags
        rd_check("R2 last events latched", 3'd4, 8'h60);
        wr(3'd4, 8'h00);
        rd_check("R3 clear all", 3'd4, 8'h00);
        pulse_evt(7'b0000011);
        rd_check("R2 stopped and error", 3'd4, 8'h03);
        wr(3'd4, 8'h02);
        rd_check("R3 partial clear", 3'd4, 8'h02);
        @(negedge clk_i);
        evt_i = 7'b0000001; reg_wr_i = 1'b1; reg_addr_i = 3'd4; reg_wdata_i = 8'h00;
        @(negedge clk_i);
        evt_i = '0; reg_wr_i = 1'b0;
        rd_check("R3 event beats clear", 3'd4, 8'h01);
        wr(3'd4, 8'h00);

        // R8 R9 R10: enable views
        wr(3'd1, 8'h01);
        rd_check("R8 plain", 3'd1, 8'h01);
        rd_check("R10 set view reads", 3'd2, 8'h01);
        rd_check("R10 clr view reads", 3'd3, 8'h01);
        wr(3'd2, 8'h02);
        rd_check("R9 set", 3'd1, 8'h03);
        wr(3'd3, 8'h01);
        rd_check("R10 clear", 3'd1, 8'h02);
        wr(3'd2, 8'h00);
        rd_check("R9 zero no effect", 3'd1, 8'h02);
        wr(3'd3, 8'h00);
        rd_check("R10 zero no effect", 3'd1, 8'h02);

        // R11: interrupt
        check("R11 idle", 32'(irq_o), 0);
        pulse_evt(7'b0000100);
        check("R11 disabled flag", 32'(irq_o), 0);
        pulse_evt(7'b0000010);
        check("R11 enabled flag", 32'(irq_o), 1);
        wr(3'd3, 8'h02);
        check("R11 enable removed", 32'(irq_o), 0);
        wr(3'd2, 8'h04);
        check("R11 enable added", 32'(irq_o), 1);
        wr(3'd4, 8'h00);
        check("R11 flags cleared", 32'(irq_o), 0);

        // R12: unmapped address
        wr(3'd0, 8'h15);
        wr(3'd5, 8'hFF);
        rd_check("R12 read zero", 3'd5, 8'h00);
        rd_check("R12 shorts kept", 3'd0, 8'h15);
        rd_check("R12 ien kept", 3'd1, 8'h04);
        rd_check("R12 flags kept", 3'd4, 8'h00);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule